// File: doc/BRIEF.md
# Flash Read/Fetch Window Guard

This block decides, for every access headed to a flash array, whether the access may go ahead or must end with an error response. Software sets a window with two bound registers, a lower and an upper bound, both kept at 64-byte granularity. It then arms the guard by writing a control word that also carries an eight-bit key. Once the guard is armed, any data read or instruction fetch whose address falls inside the window gets an error. Program and erase writes are never judged. The guard treats every bus master the same way.

Arming is one-way until reset. After the guard is armed, the bound registers stop accepting writes and no write can disarm it. A window whose lower bound lies above its upper bound protects nothing. The verdict is computed combinationally from the presented address and access kind. It is then registered once, so it leaves the block one cycle later, aligned with the flash read data.

Top module: `rxp_guard`

## Requirements
- R1: While armed, a read (`chk_kind` 2'b00) or fetch (`chk_kind` 2'b01) whose 64-byte block number `chk_addr[31:6]` lies between the lower and upper block numbers, both included, gets `rsp_err`=1. An access outside that range gets `rsp_err`=0.
- R2: The master ID has no effect on the verdict. `rsp_master` returns the ID of the access being answered.
- R3: Writes with `cfg_sel` 2'b00 (lower) or 2'b01 (upper) keep only `cfg_wdata[31:6]`. Reading back at the same select returns the stored block number with bits [5:0] at zero. The window runs from the lower block's first byte to the upper block's last byte.
- R4: A write with `cfg_sel` 2'b10 arms the guard only when `cfg_wdata[15:8]` is 8'h76 and `cfg_wdata[0]` is 1. Any other key, or bit 0 at zero, leaves the armed state unchanged.
- R5: `prot_active`, and `cfg_rdata` bit 0 at select 2'b10 or 2'b11, always show the armed state. The other readback bits at those selects are 0.
- R6: If the lower block number exceeds the upper block number, no access gets an error, even while armed.
- R7: Once armed, the guard stays armed until reset, and writes to either bound register are ignored.
- R8: Program (2'b10) and erase (2'b11) accesses always get `rsp_err`=0.
- R9: After reset the guard is disarmed, both bounds read 0 and `rsp_valid` is 0.
- R10: `rsp_valid` is high in the cycle after `chk_valid`, and only then. An access presented in the same cycle as the arming write is judged by the state before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 00 lower, 01 upper, 10 arm, 11 status |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| prot_active | output | 1 | Guard armed |
| chk_valid | input | 1 | Access presented for judgement |
| chk_addr | input | 32 | Byte address of the access |
| chk_kind | input | 2 | 00 read, 01 fetch, 10 program, 11 erase |
| chk_master | input | 4 | Requesting master ID |
| rsp_valid | output | 1 | Verdict valid (one cycle after the access) |
| rsp_err | output | 1 | Access refused |
| rsp_master | output | 4 | Master ID of the judged access |

## Verification
An arming write and a judged access can land in the same clock cycle. The access must then see the state from before the write: it is allowed, and the access that follows is refused. The bench provokes this with a directed case that drives the keyed write and an in-window read on the same clock edge. It then expects `rsp_err`=0 for that read and `prot_active`=1 afterwards, and checks that the next in-window read is refused. Bound writes that arrive after arming are also mixed with accesses, and the window must stay put.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic [1:0] {
    CFG_LO   = 2'b00,
    CFG_HI   = 2'b01,
    CFG_ARM  = 2'b10,
    CFG_STAT = 2'b11
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_FETCH = 2'b01,
    ACC_PROG  = 2'b10,
    ACC_ERASE = 2'b11
  } acc_kind_e;

  localparam int unsigned KEY_LSB = 8;
  localparam int unsigned KEY_W   = 8;
  localparam logic [KEY_W-1:0] ARM_KEY = 8'h76;
endpackage

// File: rtl/rxp_bound_reg.sv
module rxp_bound_reg #(
  parameter int unsigned BLK_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_blk,
  output logic [BLK_W-1:0] blk_q
);
  logic [BLK_W-1:0] blk_d;

  always_comb begin
    blk_d = blk_q;
    if (wr_en) blk_d = wr_blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= '0;
    else        blk_q <= blk_d;
  end
endmodule

// File: rtl/rxp_arm_ctrl.sv
module rxp_arm_ctrl #(
  parameter int unsigned   KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = 8'h76
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_arm,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             wr_set,
  output logic             armed_q
);
  logic armed_d;

  // Sticky: only a keyed write with the set bit can raise it; nothing lowers it.
  always_comb begin
    armed_d = armed_q;
    if (wr_arm && (wr_key == KEY) && wr_set) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/rxp_window_cmp.sv
module rxp_window_cmp #(
  parameter int unsigned BLK_W = 26
) (
  input  logic             armed,
  input  logic [BLK_W-1:0] lo_blk,
  input  logic [BLK_W-1:0] hi_blk,
  input  logic [BLK_W-1:0] acc_blk,
  input  logic [1:0]       acc_kind,
  output logic             hit
);
  logic judged_kind;
  logic above_lo;
  logic below_hi;

  always_comb begin
    judged_kind = (acc_kind == rxp_pkg::ACC_READ) || (acc_kind == rxp_pkg::ACC_FETCH);
    above_lo    = (acc_blk >= lo_blk);
    below_hi    = (acc_blk <= hi_blk);
    // An inverted window cannot satisfy both comparisons, so it protects nothing.
    hit         = armed && judged_kind && above_lo && below_hi;
  end
endmodule

// File: rtl/rxp_guard.sv
module rxp_guard #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BLK_LSB = 6,
  parameter int unsigned MID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              prot_active,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [1:0]        chk_kind,
  input  logic [MID_W-1:0]  chk_master,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [MID_W-1:0]  rsp_master
);
  import rxp_pkg::*;

  localparam int unsigned BLK_W   = ADDR_W - BLK_LSB;
  localparam int unsigned N_BOUND = 2;

  logic [BLK_W-1:0] bound_q [N_BOUND];
  logic [BLK_W-1:0] lo_blk;
  logic [BLK_W-1:0] hi_blk;
  logic             armed;
  logic             hit;
  logic             unused_bits;

  // Lower bound at select 0, upper bound at select 1; frozen once armed.
  for (genvar b = 0; b < N_BOUND; b++) begin : g_bound
    logic wr_this;
    assign wr_this = cfg_wr && !armed && (cfg_sel == 2'(b));
    rxp_bound_reg #(.BLK_W(BLK_W)) u_bound (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_this),
      .wr_blk (cfg_wdata[ADDR_W-1:BLK_LSB]),
      .blk_q  (bound_q[b])
    );
  end

  assign lo_blk = bound_q[0];
  assign hi_blk = bound_q[1];

  rxp_arm_ctrl #(.KEY_W(KEY_W), .KEY(ARM_KEY)) u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_arm  (cfg_wr && (cfg_sel == CFG_ARM)),
    .wr_key  (cfg_wdata[KEY_LSB+KEY_W-1:KEY_LSB]),
    .wr_set  (cfg_wdata[0]),
    .armed_q (armed)
  );

  rxp_window_cmp #(.BLK_W(BLK_W)) u_cmp (
    .armed    (armed),
    .lo_blk   (lo_blk),
    .hi_blk   (hi_blk),
    .acc_blk  (chk_addr[ADDR_W-1:BLK_LSB]),
    .acc_kind (chk_kind),
    .hit      (hit)
  );

  always_comb begin
    unique case (cfg_sel)
      CFG_LO:  cfg_rdata = {lo_blk, {BLK_LSB{1'b0}}};
      CFG_HI:  cfg_rdata = {hi_blk, {BLK_LSB{1'b0}}};
      default: cfg_rdata = {{(ADDR_W-1){1'b0}}, armed};
    endcase
  end

  assign prot_active = armed;

  // Verdict pipeline: one register stage, loaded every cycle.
  logic             rv_d, re_d;
  logic [MID_W-1:0] rm_d;

  always_comb begin
    rv_d = chk_valid;
    re_d = chk_valid && hit;
    rm_d = chk_valid ? chk_master : rsp_master;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_master <= '0;
    end else begin
      rsp_valid  <= rv_d;
      rsp_err    <= re_d;
      rsp_master <= rm_d;
    end
  end

  assign unused_bits = ^{cfg_wdata[BLK_LSB-1:1], chk_addr[BLK_LSB-1:0]};
endmodule

// File: rtl/rxp_guard_chk.sv
module rxp_guard_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BLK_LSB = 6,
  parameter int unsigned MID_W   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_wr,
  input logic [1:0]                cfg_sel,
  input logic [ADDR_W-1:0]         cfg_wdata,
  input logic                      prot_active,
  input logic                      chk_valid,
  input logic [1:0]                chk_kind,
  input logic [MID_W-1:0]          chk_master,
  input logic                      rsp_valid,
  input logic                      rsp_err,
  input logic [MID_W-1:0]          rsp_master,
  input logic [ADDR_W-BLK_LSB-1:0] lo_blk,
  input logic [ADDR_W-BLK_LSB-1:0] hi_blk
);
  import rxp_pkg::*;

  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid);
  // R10
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !rsp_valid);
  // R2
  master_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> (rsp_master == $past(chk_master)));
  // R7
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_active |=> prot_active);
  // R7
  bounds_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_active |=> ($stable(lo_blk) && $stable(hi_blk)));
  // R8
  write_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_kind[1]) |=> !rsp_err);
  // R5
  unarmed_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_active |=> !rsp_err);
  // R4
  keyed_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_active) |-> $past(cfg_wr && (cfg_sel == CFG_ARM) &&
      (cfg_wdata[KEY_LSB+KEY_W-1:KEY_LSB] == ARM_KEY) && cfg_wdata[0]));
  // R6
  inverted_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && (lo_blk > hi_blk)) |=> !rsp_err);
  // R1
  err_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
endmodule

bind rxp_guard rxp_guard_chk #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .MID_W(MID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .prot_active(prot_active), .chk_valid(chk_valid), .chk_kind(chk_kind),
  .chk_master(chk_master), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_master(rsp_master), .lo_blk(lo_blk), .hi_blk(hi_blk)
);

// File: tb/rxp_guard_tb_top.sv
module rxp_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        prot_active;
  logic        chk_valid;
  logic [31:0] chk_addr;
  logic [1:0]  chk_kind;
  logic [3:0]  chk_master;
  logic        rsp_valid;
  logic        rsp_err;
  logic [3:0]  rsp_master;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [25:0] m_lo, m_hi;
  logic        m_en;

  always #2 clk = ~clk;

  rxp_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .prot_active(prot_active), .chk_valid(chk_valid),
    .chk_addr(chk_addr), .chk_kind(chk_kind), .chk_master(chk_master),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_master(rsp_master)
  );

  function automatic bit exp_err(input logic [31:0] a, input logic [1:0] k);
    return m_en && !k[1] && (a[31:6] >= m_lo) && (a[31:6] <= m_hi);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [1:0] sel, input logic [31:0] d);
    if (sel == 2'b00 && !m_en) m_lo = d[31:6];
    if (sel == 2'b01 && !m_en) m_hi = d[31:6];
    if (sel == 2'b10 && d[15:8] == 8'h76 && d[0]) m_en = 1'b1;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_write(sel, d);
  endtask

  task automatic read_reg(input logic [1:0] sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    check(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] k, input logic [3:0] m, input string req);
    bit e;
    e = exp_err(a, k);
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = a; chk_kind = k; chk_master = m;
    @(negedge clk);
    chk_valid = 1'b0;
    check(rsp_valid && rsp_err == e && rsp_master == m, req,
          {27'd0, rsp_master, rsp_err}, {27'd0, m, e});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'b00; cfg_wdata = '0;
    chk_valid = 1'b0; chk_addr = '0; chk_kind = 2'b00; chk_master = '0;
    m_lo = '0; m_hi = '0; m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lo_a, hi_a;
    void'($urandom(32'd2024));
    do_reset();

    // R9 reset state
    check(prot_active == 1'b0, "R9", {31'd0, prot_active}, 32'd0);
    check(rsp_valid == 1'b0, "R9", {31'd0, rsp_valid}, 32'd0);
    read_reg(2'b00, 32'd0, "R9");
    read_reg(2'b01, 32'd0, "R9");
    read_reg(2'b11, 32'd0, "R9 R5");

    // R3 granularity
    cfg_write(2'b00, 32'h0000_1047);
    read_reg(2'b00, 32'h0000_1040, "R3");
    cfg_write(2'b01, 32'h0000_20FF);
    read_reg(2'b01, 32'h0000_20C0, "R3");

    // R4 wrong key, right key without set bit
    cfg_write(2'b10, 32'h0000_7501);
    check(prot_active == 1'b0, "R4", {31'd0, prot_active}, 32'd0);
    cfg_write(2'b10, 32'h0000_7600);
    check(prot_active == 1'b0, "R4", {31'd0, prot_active}, 32'd0);
    access(32'h0000_1500, 2'b00, 4'd1, "R1 disarmed");

    // random phase while disarmed: bounds and non-key arm writes
    for (int i = 0; i < 150; i++) begin
      int r = $urandom_range(0, 3);
      if (r == 0) cfg_write(2'($urandom_range(0, 1)), $urandom_range(0, 8191));
      else if (r == 1) begin
        logic [7:0] k = 8'($urandom_range(0, 255));
        if (k == 8'h76) k = 8'h77;
        cfg_write(2'b10, {16'd0, k, 8'h01});
        check(prot_active == 1'b0, "R4", {31'd0, prot_active}, 32'd0);
      end else access($urandom_range(0, 8191), 2'($urandom_range(0, 3)), 4'($urandom), "R1 R8");
    end

    // R10 same-cycle arm and access
    cfg_write(2'b00, 32'h0000_1000);
    cfg_write(2'b01, 32'h0000_1FC0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'b10; cfg_wdata = 32'h0000_7601;
    chk_valid = 1'b1; chk_addr = 32'h0000_1800; chk_kind = 2'b00; chk_master = 4'd3;
    @(negedge clk);
    cfg_wr = 1'b0; chk_valid = 1'b0;
    check(rsp_valid && !rsp_err, "R10", {30'd0, rsp_valid, rsp_err}, 32'd2);
    check(prot_active == 1'b1, "R4 R5", {31'd0, prot_active}, 32'd1);
    model_write(2'b10, 32'h0000_7601);
    read_reg(2'b10, 32'd1, "R5");
    read_reg(2'b11, 32'd1, "R5");
    access(32'h0000_1800, 2'b00, 4'd3, "R10 R1");

    // R1 R3 window edges
    access(32'h0000_0FFF, 2'b00, 4'd0, "R1 below");
    access(32'h0000_1000, 2'b00, 4'd0, "R1 R3 low edge");
    access(32'h0000_1FFF, 2'b01, 4'd0, "R1 R3 high edge");
    access(32'h0000_2000, 2'b01, 4'd0, "R1 above");
    // R2 all masters alike
    for (int m = 0; m < 16; m++) access(32'h0000_1234, 2'b01, 4'(m), "R2");
    // R8 writes pass
    access(32'h0000_1100, 2'b10, 4'd2, "R8");
    access(32'h0000_1100, 2'b11, 4'd5, "R8");
    // R7 bounds frozen and no disarm
    cfg_write(2'b00, 32'h0000_3000);
    cfg_write(2'b01, 32'h0000_0040);
    read_reg(2'b00, 32'h0000_1000, "R7");
    read_reg(2'b01, 32'h0000_1FC0, "R7");
    cfg_write(2'b10, 32'h0000_7600);
    check(prot_active == 1'b1, "R7", {31'd0, prot_active}, 32'd1);
    access(32'h0000_1010, 2'b00, 4'd9, "R7 R1");

    // random phase while armed
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 4) == 0)
        cfg_write(2'($urandom_range(0, 2)), $urandom);
      else access($urandom_range(0, 12287), 2'($urandom_range(0, 3)), 4'($urandom), "R1 R7 R8");
    end

    // R6 inverted window
    do_reset();
    cfg_write(2'b00, 32'h0000_2000);
    cfg_write(2'b01, 32'h0000_1000);
    cfg_write(2'b10, 32'h0000_7601);
    check(prot_active == 1'b1, "R6", {31'd0, prot_active}, 32'd1);
    access(32'h0000_1800, 2'b00, 4'd1, "R6");
    access(32'h0000_2000, 2'b01, 4'd1, "R6");
    access(32'h0000_1000, 2'b00, 4'd1, "R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule